// File: doc/BRIEF.md
# Memory-Resident Counter Data-Break Transfer Engine

This block moves 12-bit words between a disk word store and main memory. It does not keep the transfer count or the memory pointer in its own registers. Both live in two fixed words of main memory, field 0. For each word the engine takes three single-cycle memory slots in turn:

1. It reads the count word, adds one, and writes it back.
2. It does the same for the pointer word.
3. It moves one data word. The data address is the memory field number placed above the freshly incremented pointer.

A transfer is started by a one-cycle strobe. The strobe carries:
- the direction,
- the 20-bit starting disk address,
- the 3-bit memory field,
- the number of installed platters.

Software arms the count word with the two's complement of the word total. The transfer ends when the count wraps to zero.

The engine guards each word in two ways. First, a disk address past the installed capacity raises a non-existent-disk error and ends the run before any access. Second, on a disk write, a 32-entry lock mask is looked up with a 5-bit index built from scattered disk-address bits. A hit blocks the store, raises a lock error and ends the run. A burst input selects either back-to-back words or a fixed idle gap between words.

Top module: `dbreak_dma_engine`

## Requirements
- R1: After reset, done is 1, busy is 0, both error flags are 0, and mem_req and dsk_req are 0.
- R2: A start strobe while idle clears done and both errors and latches direction, disk address, field, platter count and burst. A strobe while busy has no effect on the running transfer.
- R3: Each word begins with two read-modify-write slots. The first is at memory address 0o7750 (count) and the second at 0o7751 (pointer), both in field 0. Each writes back its value plus one, modulo 4096. The data slot follows and uses the new pointer value.
- R4: Every data access uses mem_addr = {field[2:0], pointer[11:0]}. A pointer wrap from 0o7777 to 0 never carries into the field.
- R5: With start_write=0, the disk word at dsk_addr is written to memory. If mem_nxm is high in that slot the store is suppressed and the transfer continues.
- R6: With start_write=1, the memory word at the data address is written to the disk at dsk_addr.
- R7: The disk address (always shown on dsk_addr) advances by one after each data slot, modulo 2^20.
- R8: If the disk address is at or above (start_platters+1)*262144 when a word begins, err_nxd is set, no memory or disk access is made, and done rises at that edge.
- R9: On a disk write, the lock index is {dsk_addr[19:18], dsk_addr[16:14]}. If lock_mask at that index is 1, no disk store happens and err_wlock is set. The count, pointer and disk address still advance, and the transfer ends after that word.
- R10: After each data slot the transfer continues while the new count is nonzero and no error is set. Otherwise done rises. In burst mode N words take 3N cycles from the start edge to done.
- R11: With burst=0, GAP_CYCLES idle cycles without requests separate words, so N words take 3N+GAP_CYCLES*(N-1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle transfer start strobe |
| start_write | input | 1 | 1: memory to disk, 0: disk to memory |
| start_disk_addr | input | 20 | First disk word address |
| start_field | input | 3 | Memory field for data accesses |
| start_platters | input | 2 | Installed platters minus one |
| burst | input | 1 | 1: words back to back, 0: idle gap between words |
| lock_mask | input | 32 | Per-region write lock bits |
| mem_req | output | 1 | Memory slot active this cycle |
| mem_we | output | 1 | Memory write this cycle |
| mem_addr | output | 15 | Memory physical address |
| mem_wdata | output | 12 | Memory write data |
| mem_rdata | input | 12 | Memory read data, valid in the same cycle |
| mem_nxm | input | 1 | Addressed memory does not exist |
| dsk_req | output | 1 | Disk slot active this cycle |
| dsk_we | output | 1 | Disk write this cycle |
| dsk_addr | output | 20 | Current disk address |
| dsk_wdata | output | 12 | Disk write data |
| dsk_rdata | input | 12 | Disk read data, valid in the same cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| err_nxd | output | 1 | Disk address beyond capacity |
| err_wlock | output | 1 | Write hit a locked region |

## Verification
Every memory and disk slot completes at the clock edge that ends its cycle. Stored words and written-back count and pointer values are therefore read from the bench models only after done, never mid-run.

Done is registered. It rises exactly 3N edges after the start edge in burst mode, plus GAP_CYCLES per gap and one more cycle when the capacity check stops a word. The bench counts edges from the start edge and compares that count at the falling edge after done is seen.

The field bits of each memory access are checked at every falling edge while a slot is active.

// File: rtl/dbreak_pkg.sv
`timescale 1ns/1ps
package dbreak_pkg;
  localparam int WORD_W = 12;
  localparam int EXT_W  = 3;
  localparam int DA_W   = 20;
  localparam int PA_W   = WORD_W + EXT_W;
  localparam int SLOT_W = 5;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CNT  = 3'd1,
    ST_ADR  = 3'd2,
    ST_XFER = 3'd3,
    ST_GAP  = 3'd4
  } seq_state_e;

  // modulo-4096 step of an in-memory counter word
  function automatic word_t word_inc(input word_t w);
    return w + word_t'(1);
  endfunction

  // field number sits above the 12-bit pointer; no carry between them
  function automatic logic [PA_W-1:0] field_join(input logic [EXT_W-1:0] f, input word_t a);
    return {f, a};
  endfunction

  // lock region index: two top address bits, then bits 16..14
  function automatic logic [SLOT_W-1:0] lock_slot(input logic [DA_W-1:0] da);
    return {da[19:18], da[16:14]};
  endfunction
endpackage

// File: rtl/dbreak_lock_check.sv
`timescale 1ns/1ps
module dbreak_lock_check
  import dbreak_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic [DA_W-1:0]  disk_addr,
  input  logic [SLOTS-1:0] mask,
  output logic             locked
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOT_W-1:0] slot;

  assign slot   = lock_slot(disk_addr);
  assign locked = mask[slot[IDX_W-1:0]];
endmodule

// File: rtl/dbreak_span_check.sv
`timescale 1ns/1ps
module dbreak_span_check
  import dbreak_pkg::*;
#(
  parameter int PLAT_LOG2  = 18,
  parameter int PLAT_SEL_W = 2
) (
  input  logic [DA_W-1:0]       disk_addr,
  input  logic [PLAT_SEL_W-1:0] plat_m1,
  output logic                  beyond
);
  localparam int LIM_W = DA_W + 1;

  logic [LIM_W-1:0] plat_cnt;
  logic [LIM_W-1:0] limit;

  always_comb begin
    plat_cnt = {{(LIM_W-PLAT_SEL_W){1'b0}}, plat_m1} + LIM_W'(1);
    limit    = plat_cnt << PLAT_LOG2;
    beyond   = {1'b0, disk_addr} >= limit;
  end
endmodule

// File: rtl/dbreak_seq.sv
`timescale 1ns/1ps
module dbreak_seq
  import dbreak_pkg::*;
#(
  parameter int    GAP_CYCLES = 3,
  parameter int    PLAT_SEL_W = 2,
  parameter word_t CNT_LOC    = 12'o7750,
  parameter word_t PTR_LOC    = 12'o7751
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_write,
  input  logic [DA_W-1:0]       start_disk_addr,
  input  logic [EXT_W-1:0]      start_field,
  input  logic [PLAT_SEL_W-1:0] start_platters,
  input  logic                  burst,
  input  logic                  beyond,
  input  logic                  locked,
  output logic [PLAT_SEL_W-1:0] plat_q,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [PA_W-1:0]       mem_addr,
  output word_t                 mem_wdata,
  input  word_t                 mem_rdata,
  input  logic                  mem_nxm,
  output logic                  dsk_req,
  output logic                  dsk_we,
  output logic [DA_W-1:0]       dsk_addr,
  output word_t                 dsk_wdata,
  input  word_t                 dsk_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  err_nxd,
  output logic                  err_wlock
);
  localparam int GAP_W = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;

  seq_state_e       state, state_nx;
  logic             dir_wr_q, burst_q;
  logic [EXT_W-1:0] ext_q;
  logic [DA_W-1:0]  da_q;
  word_t            cnt_q, ptr_q;
  logic [GAP_W-1:0] gap_cnt;
  logic             done_q, nxd_q, wl_q;

  // named events for the checks below
  logic ev_accept, ev_nxd_hit, ev_lock_hit, ev_word_done, ev_more, gap_last;

  assign ev_accept    = (state == ST_IDLE) && start;
  assign ev_nxd_hit   = (state == ST_CNT) && beyond;
  assign ev_word_done = (state == ST_XFER);
  assign ev_lock_hit  = ev_word_done && dir_wr_q && locked;
  assign ev_more      = (cnt_q != '0) && !ev_lock_hit;

  generate
    if (GAP_CYCLES > 0) begin : g_gap
      assign gap_last = (gap_cnt == GAP_W'(GAP_CYCLES - 1));
    end else begin : g_nogap
      assign gap_last = 1'b1;
    end
  endgenerate

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start) state_nx = ST_CNT;
      ST_CNT:  state_nx = beyond ? ST_IDLE : ST_ADR;
      ST_ADR:  state_nx = ST_XFER;
      ST_XFER: begin
        if (!ev_more)                          state_nx = ST_IDLE;
        else if (burst_q || GAP_CYCLES == 0)   state_nx = ST_CNT;
        else                                   state_nx = ST_GAP;
      end
      ST_GAP:  if (gap_last) state_nx = ST_CNT;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    dsk_req   = 1'b0;
    dsk_we    = 1'b0;
    dsk_wdata = '0;
    case (state)
      ST_CNT: if (!beyond) begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = field_join('0, CNT_LOC);
        mem_wdata = word_inc(mem_rdata);
      end
      ST_ADR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = field_join('0, PTR_LOC);
        mem_wdata = word_inc(mem_rdata);
      end
      ST_XFER: begin
        mem_req  = 1'b1;
        mem_addr = field_join(ext_q, ptr_q);
        dsk_req  = 1'b1;
        if (dir_wr_q) begin
          dsk_we    = !locked;
          dsk_wdata = mem_rdata;
        end else begin
          mem_we    = !mem_nxm;
          mem_wdata = dsk_rdata;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      dir_wr_q <= 1'b0;
      burst_q  <= 1'b0;
      ext_q    <= '0;
      plat_q   <= '0;
      da_q     <= '0;
      cnt_q    <= '0;
      ptr_q    <= '0;
      gap_cnt  <= '0;
      done_q   <= 1'b1;
      nxd_q    <= 1'b0;
      wl_q     <= 1'b0;
    end else begin
      state <= state_nx;
      case (state)
        ST_IDLE: if (start) begin
          dir_wr_q <= start_write;
          burst_q  <= burst;
          ext_q    <= start_field;
          plat_q   <= start_platters;
          da_q     <= start_disk_addr;
          done_q   <= 1'b0;
          nxd_q    <= 1'b0;
          wl_q     <= 1'b0;
        end
        ST_CNT: begin
          if (beyond) begin
            nxd_q  <= 1'b1;
            done_q <= 1'b1;
          end else begin
            cnt_q <= word_inc(mem_rdata);
          end
        end
        ST_ADR: ptr_q <= word_inc(mem_rdata);
        ST_XFER: begin
          da_q    <= da_q + DA_W'(1);
          gap_cnt <= '0;
          if (ev_lock_hit) wl_q <= 1'b1;
          if (!ev_more) done_q <= 1'b1;
        end
        ST_GAP: gap_cnt <= gap_cnt + GAP_W'(1);
        default: ;
      endcase
    end
  end

  assign dsk_addr  = da_q;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign err_nxd   = nxd_q;
  assign err_wlock = wl_q;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (busy && !done && !err_nxd && !err_wlock)); // R2
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(dir_wr_q) && $stable(ext_q) && $stable(plat_q))); // R2
  AST_CNT_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CNT && !beyond) |-> (mem_req && mem_we && mem_addr == PA_W'(CNT_LOC)
      && (mem_wdata - mem_rdata) == WORD_W'(1))); // R3
  AST_PTR_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADR) |-> (mem_req && mem_we && mem_addr == PA_W'(PTR_LOC) && !dsk_req)); // R3
  AST_FIELD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_done |-> (mem_addr[PA_W-1:WORD_W] == ext_q)); // R4
  AST_NXM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_word_done && !dir_wr_q && mem_nxm) |-> !mem_we); // R5
  AST_DA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_word_done |=> (dsk_addr == $past(dsk_addr) + DA_W'(1))); // R7
  AST_NXD_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nxd_hit |-> (!mem_req && !dsk_req)); // R8
  AST_NXD_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nxd_hit |=> (done && err_nxd && !busy)); // R8
  AST_NO_LOCKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (dsk_req && dsk_we) |-> !locked); // R9
  AST_LOCK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock_hit |=> (done && err_wlock)); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> (!mem_req && !dsk_req)); // R11
endmodule

// File: rtl/dbreak_dma_engine.sv
`timescale 1ns/1ps
module dbreak_dma_engine
  import dbreak_pkg::*;
#(
  parameter int GAP_CYCLES = 3,
  parameter int PLAT_LOG2  = 18,
  parameter int PLAT_SEL_W = 2,
  parameter int LOCK_SLOTS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  start_write,
  input  logic [DA_W-1:0]       start_disk_addr,
  input  logic [EXT_W-1:0]      start_field,
  input  logic [PLAT_SEL_W-1:0] start_platters,
  input  logic                  burst,
  input  logic [LOCK_SLOTS-1:0] lock_mask,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [PA_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]     mem_wdata,
  input  logic [WORD_W-1:0]     mem_rdata,
  input  logic                  mem_nxm,
  output logic                  dsk_req,
  output logic                  dsk_we,
  output logic [DA_W-1:0]       dsk_addr,
  output logic [WORD_W-1:0]     dsk_wdata,
  input  logic [WORD_W-1:0]     dsk_rdata,
  output logic                  busy,
  output logic                  done,
  output logic                  err_nxd,
  output logic                  err_wlock
);
  logic                  beyond;
  logic                  locked;
  logic [PLAT_SEL_W-1:0] plat_q;

  dbreak_span_check #(
    .PLAT_LOG2 (PLAT_LOG2),
    .PLAT_SEL_W(PLAT_SEL_W)
  ) u_span (
    .disk_addr(dsk_addr),
    .plat_m1  (plat_q),
    .beyond   (beyond)
  );

  dbreak_lock_check #(
    .SLOTS(LOCK_SLOTS)
  ) u_lock (
    .disk_addr(dsk_addr),
    .mask     (lock_mask),
    .locked   (locked)
  );

  dbreak_seq #(
    .GAP_CYCLES(GAP_CYCLES),
    .PLAT_SEL_W(PLAT_SEL_W)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .start_write    (start_write),
    .start_disk_addr(start_disk_addr),
    .start_field    (start_field),
    .start_platters (start_platters),
    .burst          (burst),
    .beyond         (beyond),
    .locked         (locked),
    .plat_q         (plat_q),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_wdata      (mem_wdata),
    .mem_rdata      (mem_rdata),
    .mem_nxm        (mem_nxm),
    .dsk_req        (dsk_req),
    .dsk_we         (dsk_we),
    .dsk_addr       (dsk_addr),
    .dsk_wdata      (dsk_wdata),
    .dsk_rdata      (dsk_rdata),
    .busy           (busy),
    .done           (done),
    .err_nxd        (err_nxd),
    .err_wlock      (err_wlock)
  );
endmodule

// File: tb/test_dbreak_dma_engine.sv
`timescale 1ns/1ps
module test_dbreak_dma_engine;
  localparam int GAP   = 3;
  localparam int MSIZE = 1024;
  localparam int CNT_I = 1000;  // low 10 bits of 0o7750
  localparam int PTR_I = 1001;  // low 10 bits of 0o7751

  typedef struct packed {
    logic        wr;
    logic        brst;
    logic [2:0]  ext;
    logic [1:0]  plat;
    logic [19:0] da;
    logic [11:0] n;
    logic [11:0] ma;
    logic [31:0] lock;
    logic [11:0] words;
    logic        nxd;
    logic        wl;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 3'd0, 2'd0, 20'h00010, 12'd4, 12'o0100, 32'h0,        12'd4, 1'b0, 1'b0},
    '{1'b1, 1'b1, 3'd2, 2'd0, 20'h00200, 12'd3, 12'o0200, 32'h0,        12'd3, 1'b0, 1'b0},
    '{1'b0, 1'b0, 3'd5, 2'd1, 20'h40000, 12'd3, 12'o7776, 32'h0,        12'd3, 1'b0, 1'b0},
    '{1'b0, 1'b1, 3'd0, 2'd0, 20'h3FFFE, 12'd4, 12'o0300, 32'h0,        12'd2, 1'b1, 1'b0},
    '{1'b1, 1'b1, 3'd0, 2'd0, 20'h08000, 12'd3, 12'o0400, 32'h00000004, 12'd1, 1'b0, 1'b1},
    '{1'b1, 1'b1, 3'd1, 2'd3, 20'hFFFFF, 12'd2, 12'o0500, 32'h00020000, 12'd2, 1'b0, 1'b0},
    '{1'b1, 1'b0, 3'd1, 2'd3, 20'h84000, 12'd2, 12'o0600, 32'h00020000, 12'd1, 1'b0, 1'b1},
    '{1'b0, 1'b1, 3'd7, 2'd0, 20'h00020, 12'd2, 12'o0700, 32'h0,        12'd2, 1'b0, 1'b0},
    '{1'b1, 1'b1, 3'd3, 2'd0, 20'h28000, 12'd2, 12'o0110, 32'h00000400, 12'd2, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start_write = 1'b0;
  logic [19:0] start_disk_addr = '0;
  logic [2:0]  start_field = '0;
  logic [1:0]  start_platters = '0;
  logic        burst = 1'b1;
  logic [31:0] lock_mask = '0;
  logic        mem_req, mem_we, mem_nxm;
  logic [14:0] mem_addr;
  logic [11:0] mem_wdata, mem_rdata;
  logic        dsk_req, dsk_we;
  logic [19:0] dsk_addr;
  logic [11:0] dsk_wdata, dsk_rdata;
  logic        busy, done, err_nxd, err_wlock;

  logic [11:0] bmem [MSIZE];
  logic [11:0] bdsk [MSIZE];
  logic [11:0] exp_mem [MSIZE];
  logic [11:0] exp_dsk [MSIZE];
  logic        fill_req = 1'b0;
  logic [11:0] fill_cnt = '0;
  logic [11:0] fill_ptr = '0;
  logic [2:0]  cur_ext = '0;
  int          bad_hi = 0;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  dbreak_dma_engine #(.GAP_CYCLES(GAP)) i_dbreak_dma_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .start_write(start_write),
    .start_disk_addr(start_disk_addr), .start_field(start_field),
    .start_platters(start_platters), .burst(burst), .lock_mask(lock_mask),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_nxm(mem_nxm), .dsk_req(dsk_req), .dsk_we(dsk_we),
    .dsk_addr(dsk_addr), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata),
    .busy(busy), .done(done), .err_nxd(err_nxd), .err_wlock(err_wlock)
  );

  function automatic logic [11:0] minit(input int k);
    return 12'((k * 37 + 5) & 12'hFFF);
  endfunction
  function automatic logic [11:0] dinit(input int k);
    return 12'((k * 11 + 12'h300) & 12'hFFF);
  endfunction

  assign mem_rdata = bmem[mem_addr[9:0]];
  assign mem_nxm   = (mem_addr[14:12] == 3'd7);
  assign dsk_rdata = bdsk[dsk_addr[9:0]];

  always @(posedge clk) begin
    if (fill_req) begin
      for (int k = 0; k < MSIZE; k++) begin
        bmem[k] <= minit(k);
        bdsk[k] <= dinit(k);
      end
      bmem[CNT_I] <= fill_cnt;
      bmem[PTR_I] <= fill_ptr;
    end else begin
      if (mem_req && mem_we) bmem[mem_addr[9:0]] <= mem_wdata;
      if (dsk_req && dsk_we) bdsk[dsk_addr[9:0]] <= dsk_wdata;
    end
  end

  // field bits of every memory slot (R4, R3)
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (mem_addr[11:0] == 12'o7750 || mem_addr[11:0] == 12'o7751) begin
        if (mem_addr[14:12] != 3'd0) bad_hi <= bad_hi + 1;
      end else if (mem_addr[14:12] != cur_ext) begin
        bad_hi <= bad_hi + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  task automatic load(input logic [11:0] n, input logic [11:0] ma);
    @(negedge clk);
    fill_cnt = 12'(-n);
    fill_ptr = ma;
    fill_req = 1'b1;
    @(negedge clk);
    fill_req = 1'b0;
    for (int k = 0; k < MSIZE; k++) begin
      exp_mem[k] = minit(k);
      exp_dsk[k] = dinit(k);
    end
    exp_mem[CNT_I] = 12'(-n);
    exp_mem[PTR_I] = ma;
  endtask

  // start strobe at one edge, count edges until done is seen
  task automatic launch(output int cyc);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(!done && busy, "R2 done cleared by start", {done, busy}, 2'b01);
    cyc = 0;
    while (!done && cyc < 600) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int          cyc, exp_cyc, mism, hi0, w;
    logic [11:0] p;
    logic [19:0] d;
    w = int'(v.words);
    load(v.n, v.ma);
    for (int i = 0; i < w; i++) begin
      p = v.ma + 12'(i + 1);
      d = v.da + 20'(i);
      if (!v.wr && v.ext != 3'd7) exp_mem[p[9:0]] = dinit(int'(d[9:0]));
      if (v.wr && !(v.wl && i == w - 1)) exp_dsk[d[9:0]] = minit(int'(p[9:0]));
    end
    exp_mem[CNT_I] = 12'(-v.n) + v.words;
    exp_mem[PTR_I] = v.ma + v.words;
    hi0 = bad_hi;
    cur_ext = v.ext;
    start_write = v.wr;
    burst = v.brst;
    start_field = v.ext;
    start_platters = v.plat;
    start_disk_addr = v.da;
    lock_mask = v.lock;
    launch(cyc);
    exp_cyc = 3 * w + (v.brst ? 0 : GAP * (w - 1)) + (v.nxd ? (1 + (v.brst ? 0 : GAP)) : 0);
    $display("[TB] vector %0d", idx);
    chk(done && !busy, "R10 done at end", {done, busy}, 2'b10);
    chk(cyc == exp_cyc, v.brst ? "R10 burst cycle count" : "R11 gapped cycle count", cyc, exp_cyc);
    chk(err_nxd == v.nxd, "R8 capacity error flag", err_nxd, v.nxd);
    chk(err_wlock == v.wl, "R9 write lock flag", err_wlock, v.wl);
    chk(dsk_addr == v.da + 20'(w), "R7 disk address advance", dsk_addr, v.da + 20'(w));
    chk(bmem[CNT_I] == exp_mem[CNT_I], "R3 count word writeback", bmem[CNT_I], exp_mem[CNT_I]);
    chk(bmem[PTR_I] == exp_mem[PTR_I], "R3 pointer word writeback", bmem[PTR_I], exp_mem[PTR_I]);
    mism = 0;
    for (int k = 0; k < MSIZE; k++) begin
      if (bmem[k] != exp_mem[k]) mism++;
      if (bdsk[k] != exp_dsk[k]) mism++;
    end
    chk(mism == 0, v.wr ? "R6 disk contents" : "R5 memory contents", mism, 0);
    chk(bad_hi == hi0, "R4 field bits on memory slots", bad_hi - hi0, 0);
  endtask

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    chk(done && !busy && !err_nxd && !err_wlock && !mem_req && !dsk_req,
        "R1 reset state", {done, busy, err_nxd, err_wlock, mem_req, dsk_req}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done && !busy, "R1 idle after reset release", {done, busy}, 2'b10);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R2: second strobe during a run is ignored
    load(12'd3, 12'o0150);
    cur_ext = 3'd0;
    start_write = 1'b0;
    burst = 1'b0;
    start_field = 3'd0;
    start_platters = 2'd0;
    start_disk_addr = 20'h00100;
    lock_mask = '0;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    start_disk_addr = 20'h00300;
    start_write = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 2;
    while (!done && cyc < 600) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    chk(dsk_addr == 20'h00103, "R2 busy strobe ignored (disk address)", dsk_addr, 20'h00103);
    chk(bmem[12'o0151 & 10'h3FF] == dinit(12'h100 & 10'h3FF), "R2 busy strobe ignored (direction)",
        bmem[12'o0151 & 10'h3FF], dinit(12'h100 & 10'h3FF));
    chk(cyc == 9 + 2 * GAP, "R11 gapped run length", cyc, 9 + 2 * GAP);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule